// File: doc/BRIEF.md
# Byte and word add/subtract unit with nibble flags

This block is the arithmetic core of a small accumulator processor. It adds or subtracts two 8-bit values with carry, compares two bytes, and runs the same add, subtract and compare across a 16-bit register pair. Each operation produces a result together with negative, zero, carry, half-carry and overflow flags. Register selection, operand fetch and flag storage stay outside: the caller supplies both operands, the stored carry, and the stored half-carry and overflow bits. A compare hands those stored bits back unchanged.

Subtraction reuses the adder. For bytes, operand B is inverted and added with the carry, so a set carry means that no borrow occurred. For words, operand B is negated as a 16-bit two's complement before it is added. Half-carry is the carry across the nibble boundary that sits four bits below the top of the operation width. This is bit 3 for bytes and bit 11 for words. A parameter selects between a purely combinational output and an output register with asynchronous reset.

Top module: `nib_alu`

## Requirements
- R1: For byte operations (codes 0, 1 and 6, 7), result_o[7:0] holds the 8-bit sum and result_o[15:8] is zero. n_o is bit 7 of the sum, and z_o is set when the sum's eight bits are all zero.
- R2: Op code 0 (byte add) forms a_i[7:0] + b_i[7:0] + c_i. c_o is the carry out of bit 7.
- R3: Op code 1 (byte subtract) forms a_i[7:0] + ~b_i[7:0] + c_i. c_o is the carry out of bit 7, so c_o=1 means no borrow.
- R4: For op codes 0 and 1, h_o is the carry out of bit 3 of that addition, with carry-in included. v_o is set when the two addends have equal sign bits and the sum's bit 7 differs from them.
- R5: Op code 2 (byte compare) evaluates a_i[7:0] - b_i[7:0] with no carry-in. c_o=1 when a_i[7:0] >= b_i[7:0]. n_o and z_o come from the 8-bit difference. h_o equals h_i, v_o equals v_i, and result_o equals a_i.
- R6: Op code 3 (word add) forms the 16-bit sum a_i + b_i with no carry-in. c_o is the carry out of bit 15, n_o is bit 15, and z_o is set only when all 16 result bits are zero.
- R7: Op code 4 (word subtract) first negates b_i as a 16-bit two's complement, truncated to 16 bits, then adds it to a_i. The flags follow R6, so subtracting zero gives c_o=0.
- R8: For op codes 3 and 4, h_o is the carry out of bit 11 of the addition. v_o is set when a_i and the added operand have equal bit 15 and the result's bit 15 differs from them.
- R9: Op code 5 (word compare) gives c_o=1 when a_i >= b_i, takes n_o from bit 15 of a_i - b_i, and sets z_o when that difference is zero. h_o equals h_i, v_o equals v_i, and result_o equals a_i.
- R10: Reserved op codes 6 and 7 behave exactly as op code 0.
- R11: With REG_OUT=1, all outputs present, one clock later, the values computed from the inputs sampled at that edge. With REG_OUT=0, the outputs follow the inputs in the same cycle.
- R12: With REG_OUT=1, all outputs are zero while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 word add, 4 word sub, 5 word cmp) |
| a_i | input | 16 | Operand A; low byte is the accumulator, full word is the pair |
| b_i | input | 16 | Operand B |
| c_i | input | 1 | Stored carry flag |
| h_i | input | 1 | Stored half-carry flag, returned by compares |
| v_i | input | 1 | Stored overflow flag, returned by compares |
| result_o | output | 16 | Result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| h_o | output | 1 | Half-carry flag |
| v_o | output | 1 | Overflow flag |

## Verification
The bench builds the default 8-bit byte width twice, once with REG_OUT=1 and once with REG_OUT=0. The two builds are compared against the same behavioural model. This brings both the one-cycle registered path with its reset value and the same-cycle combinational path into reach. Directed vectors cover the points where the flags change:
- byte and word wrap-around at 0xFF and 0xFFFF,
- the nibble carries at bit 3 and bit 11,
- signed overflow at 0x7F and 0x7FFF,
- the word subtract of zero,
- equal and smaller compares, and the reserved codes.

Random operands then cover the remaining cases.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADC  = 3'd0,
    OP_SBC  = 3'd1,
    OP_CMP  = 3'd2,
    OP_ADDW = 3'd3,
    OP_SUBW = 3'd4,
    OP_CMPW = 3'd5
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic h;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/nib_adder.sv
// Adder split at the top nibble: exposes carry into bit W-4 and into the MSB.
module nib_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         nib_c_o,
  output logic         ovf_o
);
  localparam int LO = W - 4;

  logic [LO:0] lo_s;
  logic [3:0]  mid_s;
  logic [1:0]  top_s;

  always_comb begin
    lo_s  = {1'b0, a_i[LO-1:0]} + {1'b0, b_i[LO-1:0]} + {{LO{1'b0}}, cin_i};
    mid_s = {1'b0, a_i[W-2:LO]} + {1'b0, b_i[W-2:LO]} + {3'b000, lo_s[LO]};
    top_s = {1'b0, a_i[W-1]} + {1'b0, b_i[W-1]} + {1'b0, mid_s[3]};
  end

  assign sum_o   = {top_s[0], mid_s[2:0], lo_s[LO-1:0]};
  assign cout_o  = top_s[1];
  assign nib_c_o = lo_s[LO];
  assign ovf_o   = top_s[1] ^ mid_s[3];
endmodule

// File: rtl/nib_byte_unit.sv
// One adder for add, subtract and compare; XOR stage on operand B.
module nib_byte_unit
  import nib_alu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              c_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              c_o,
  output logic              h_o,
  output logic              v_o
);
  logic              inv_b;
  logic              cin;
  logic [BYTE_W-1:0] b_x;

  always_comb begin
    inv_b = (op_i == OP_SBC) || (op_i == OP_CMP);
    cin   = (op_i == OP_CMP) ? 1'b1 : c_i;
    b_x   = b_i ^ {BYTE_W{inv_b}};
  end

  nib_adder #(.W(BYTE_W)) u_add (
    .a_i    (a_i),
    .b_i    (b_x),
    .cin_i  (cin),
    .sum_o  (res_o),
    .cout_o (c_o),
    .nib_c_o(h_o),
    .ovf_o  (v_o)
  );
endmodule

// File: rtl/nib_word_unit.sv
// Pair-width path: subtract negates the operand, compare uses invert plus one.
module nib_word_unit
  import nib_alu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  alu_op_e           op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] res_o,
  output logic              c_o,
  output logic              h_o,
  output logic              v_o
);
  logic [WORD_W-1:0] opnd;
  logic              cin;

  always_comb begin
    unique case (op_i)
      OP_SUBW: begin opnd = (~b_i) + {{(WORD_W-1){1'b0}}, 1'b1}; cin = 1'b0; end
      OP_CMPW: begin opnd = ~b_i; cin = 1'b1; end
      default: begin opnd = b_i;  cin = 1'b0; end
    endcase
  end

  nib_adder #(.W(WORD_W)) u_add (
    .a_i    (a_i),
    .b_i    (opnd),
    .cin_i  (cin),
    .sum_o  (res_o),
    .cout_o (c_o),
    .nib_c_o(h_o),
    .ovf_o  (v_o)
  );
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0]            op_i,
  input  logic [2*BYTE_W-1:0]   a_i,
  input  logic [2*BYTE_W-1:0]   b_i,
  input  logic                  c_i,
  input  logic                  h_i,
  input  logic                  v_i,
  output logic [2*BYTE_W-1:0]   result_o,
  output logic                  n_o,
  output logic                  z_o,
  output logic                  c_o,
  output logic                  h_o,
  output logic                  v_o
);
  localparam int WORD_W = 2 * BYTE_W;

  alu_op_e           op;
  logic              is_word, is_cmp;
  logic [BYTE_W-1:0] b_res;
  logic              b_c, b_h, b_v;
  logic [WORD_W-1:0] w_res;
  logic              w_c, w_h, w_v;
  logic [WORD_W-1:0] res_c;
  alu_flags_t        f_c;

  // reserved codes fold onto byte add
  always_comb begin
    unique case (op_i)
      3'd1:    op = OP_SBC;
      3'd2:    op = OP_CMP;
      3'd3:    op = OP_ADDW;
      3'd4:    op = OP_SUBW;
      3'd5:    op = OP_CMPW;
      default: op = OP_ADC;
    endcase
  end

  nib_byte_unit #(.BYTE_W(BYTE_W)) u_byte (
    .op_i (op),
    .a_i  (a_i[BYTE_W-1:0]),
    .b_i  (b_i[BYTE_W-1:0]),
    .c_i  (c_i),
    .res_o(b_res),
    .c_o  (b_c),
    .h_o  (b_h),
    .v_o  (b_v)
  );

  nib_word_unit #(.WORD_W(WORD_W)) u_word (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(w_res),
    .c_o  (w_c),
    .h_o  (w_h),
    .v_o  (w_v)
  );

  always_comb begin
    is_word = (op == OP_ADDW) || (op == OP_SUBW) || (op == OP_CMPW);
    is_cmp  = (op == OP_CMP)  || (op == OP_CMPW);
    if (is_cmp)       res_c = a_i;
    else if (is_word) res_c = w_res;
    else              res_c = {{BYTE_W{1'b0}}, b_res};
    f_c.n = is_word ? w_res[WORD_W-1] : b_res[BYTE_W-1];
    f_c.z = is_word ? (w_res == '0) : (b_res == '0);
    f_c.c = is_word ? w_c : b_c;
    f_c.h = is_cmp ? h_i : (is_word ? w_h : b_h);
    f_c.v = is_cmp ? v_i : (is_word ? w_v : b_v);
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [WORD_W-1:0] res_q;
      alu_flags_t        f_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          res_q <= '0;
          f_q   <= '0;
        end else begin
          res_q <= res_c;
          f_q   <= f_c;
        end
      end
      assign result_o = res_q;
      assign {n_o, z_o, c_o, h_o, v_o} = f_q;

      a_r11_reg_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (result_o == $past(res_c)) &&
                 ({n_o, z_o, c_o, h_o, v_o} == $past(f_c)));
    end else begin : g_comb
      assign result_o = res_c;
      assign {n_o, z_o, c_o, h_o, v_o} = f_c;
    end
  endgenerate

  a_r2_adc_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0) |->
      ({f_c.c, res_c[BYTE_W-1:0]} ==
       ({1'b0, a_i[BYTE_W-1:0]} + {1'b0, b_i[BYTE_W-1:0]} + {{BYTE_W{1'b0}}, c_i})));

  a_r1_byte_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 || op_i == 3'd1 || op_i >= 3'd6) |-> (res_c[WORD_W-1:BYTE_W] == '0));

  a_r5_cmp_keeps_vh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2) |-> (f_c.h == h_i) && (f_c.v == v_i) && (res_c == a_i) &&
                       (f_c.c == (a_i[BYTE_W-1:0] >= b_i[BYTE_W-1:0])));

  a_r9_cmpw_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5) |-> (f_c.c == (a_i >= b_i)) && (f_c.z == (a_i == b_i)) &&
                       (f_c.h == h_i) && (f_c.v == v_i));

  a_r7_subw_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && b_i == '0) |-> (res_c == a_i) && !f_c.c && !f_c.v);
endmodule

// File: tb/tb_nib_alu.sv
`timescale 1ns/1ps
module tb_nib_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] a = 16'h0005, b = 16'h0003;
  logic        ci = 1'b0, vi = 1'b0, hi = 1'b0;
  logic [15:0] r_res, k_res;
  logic        r_n, r_z, r_c, r_h, r_v, k_n, k_z, k_c, k_h, k_v;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  bit          prev_valid = 1'b0;
  logic [20:0] prev_exp;
  int          prev_op;

  always #4 clk = ~clk;

  nib_alu #(.BYTE_W(8), .REG_OUT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .a_i(a), .b_i(b), .c_i(ci), .h_i(hi), .v_i(vi),
    .result_o(r_res), .n_o(r_n), .z_o(r_z), .c_o(r_c), .h_o(r_h), .v_o(r_v));

  nib_alu #(.BYTE_W(8), .REG_OUT(1'b0)) dut_comb (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .a_i(a), .b_i(b), .c_i(ci), .h_i(hi), .v_i(vi),
    .result_o(k_res), .n_o(k_n), .z_o(k_z), .c_o(k_c), .h_o(k_h), .v_o(k_v));

  function automatic int sx(int x, int w);
    return (x >= (1 << (w - 1))) ? x - (1 << w) : x;
  endfunction

  // {res[15:0], n, z, c, h, v}
  function automatic logic [20:0] model(int o, int aa, int bb, int cc, int vv, int hh);
    int a8 = aa & 255, b8 = bb & 255, ob, s, r, n, z, c, h, v, sr, w;
    case (o)
      2: begin
        s = a8 - b8; c = (a8 >= b8) ? 1 : 0; r = aa;
        n = ((s & 255) >> 7) & 1; z = ((s & 255) == 0) ? 1 : 0; v = vv; h = hh;
      end
      3, 4: begin
        w = (o == 4) ? ((65536 - bb) & 65535) : bb;
        s = aa + w; r = s & 65535; c = (s >> 16) & 1;
        h = (((aa & 4095) + (w & 4095)) >> 12) & 1;
        sr = sx(aa, 16) + sx(w, 16); v = (sr > 32767 || sr < -32768) ? 1 : 0;
        n = (r >> 15) & 1; z = (r == 0) ? 1 : 0;
      end
      5: begin
        s = aa - bb; c = (aa >= bb) ? 1 : 0; r = aa;
        n = ((s & 65535) >> 15) & 1; z = ((s & 65535) == 0) ? 1 : 0; v = vv; h = hh;
      end
      default: begin
        ob = (o == 1) ? (255 - b8) : b8;
        s = a8 + ob + cc; r = s & 255; c = (s >> 8) & 1;
        h = (((a8 & 15) + (ob & 15) + cc) >> 4) & 1;
        sr = sx(a8, 8) + sx(ob, 8) + cc; v = (sr > 127 || sr < -128) ? 1 : 0;
        n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
      end
    endcase
    return {16'(r), 1'(n), 1'(z), 1'(c), 1'(h), 1'(v)};
  endfunction

  function automatic string tag_of(int o, int f, bit reg_path);
    if (reg_path) return "R11";
    if (o >= 6) return "R10";
    case (o)
      0: return (f == 3) ? "R2" : (f >= 4) ? "R4" : "R1";
      1: return (f == 3) ? "R3" : (f >= 4) ? "R4" : "R1";
      2: return "R5";
      3: return (f >= 4) ? "R8" : "R6";
      4: return (f >= 4) ? "R8" : "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(string who, int o, bit reg_path, logic [20:0] act, logic [20:0] exp);
    string names [6] = '{"result", "n", "z", "c", "h", "v"};
    for (int f = 0; f < 6; f++) begin
      logic [15:0] av, ev;
      av = (f == 0) ? act[20:5] : 16'(act[5 - f]);
      ev = (f == 0) ? exp[20:5] : 16'(exp[5 - f]);
      checks++;
      if (av !== ev) begin
        errors++;
        $display("FAIL %s %s op=%0d %s: actual %h expected %h", tag_of(o, f, reg_path), who, o,
                 names[f], av, ev);
      end
    end
  endtask

  // reference comparison on every falling edge
  always @(negedge clk) begin
    if (!rst_ni) prev_valid <= 1'b0;
    else if (!done) begin
      logic [20:0] e;
      e = model(int'(op), int'(a), int'(b), int'(ci), int'(vi), int'(hi));
      compare("comb", int'(op), 1'b0, {k_res, k_n, k_z, k_c, k_h, k_v}, e);
      if (prev_valid) compare("reg", prev_op, 1'b1, {r_res, r_n, r_z, r_c, r_h, r_v}, prev_exp);
      prev_exp   <= e;
      prev_op    <= int'(op);
      prev_valid <= 1'b1;
    end
  end

  task automatic drive(int o, int aa, int bb, int cc, int vv, int hh);
    @(posedge clk);
    #1;
    op = 3'(o); a = 16'(aa); b = 16'(bb); ci = 1'(cc); vi = 1'(vv); hi = 1'(hh);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R12 reset value
    if ({r_res, r_n, r_z, r_c, r_h, r_v} !== 21'd0) begin
      errors++;
      $display("FAIL R12 reset outputs: actual %h expected 0", {r_res, r_n, r_z, r_c, r_h, r_v});
    end
    @(posedge clk); #1 rst_ni = 1'b1;
    // byte corners
    drive(0, 'hFF, 'h01, 0, 0, 0);   // R2 wrap, zero
    drive(0, 'h0F, 'h00, 1, 0, 0);   // R4 half-carry from carry-in
    drive(0, 'h7F, 'h01, 0, 0, 0);   // R4 overflow
    drive(0, 'h80, 'h80, 0, 0, 0);   // R4 negative overflow
    drive(1, 'h00, 'h01, 1, 0, 0);   // R3 borrow
    drive(1, 'h05, 'h03, 0, 0, 0);   // R3 carry clear adds extra borrow
    drive(1, 'h80, 'h01, 1, 0, 0);   // R4 subtract overflow
    drive(2, 'h1234, 'h0034, 0, 1, 1); // R5 equal
    drive(2, 'h0010, 'h0020, 1, 0, 1); // R5 smaller
    // word corners
    drive(3, 'hFFFF, 'h0001, 1, 0, 0); // R6 wrap
    drive(3, 'h0FFF, 'h0001, 0, 0, 0); // R8 half-carry bit 11
    drive(3, 'h7FFF, 'h0001, 0, 0, 0); // R8 overflow
    drive(4, 'h1234, 'h0000, 1, 0, 0); // R7 subtract zero
    drive(4, 'h8000, 'h0001, 0, 0, 0); // R8 subtract overflow
    drive(4, 'h0001, 'h0002, 0, 0, 0); // R7 borrow
    drive(5, 'hABCD, 'hABCD, 0, 1, 0); // R9 equal
    drive(5, 'h0100, 'h0200, 0, 0, 1); // R9 smaller
    drive(6, 'h00F0, 'h0010, 1, 0, 0); // R10
    drive(7, 'h7F7F, 'h0101, 0, 1, 1); // R10
    for (int i = 0; i < 3000; i++)
      drive(int'($urandom_range(0, 7)), int'($urandom_range(0, 65535)),
            int'($urandom_range(0, 65535)), int'($urandom_range(0, 1)),
            int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule